// File: doc/BRIEF.md
# Address-Decoding Wait-State Generator

This block sits beside a small 8-bit processor on the processor clock, which is the crystal frequency divided by two. It turns the 16-bit address bus into chip selects for ROM, RAM and sixteen peripheral slots, all active low. It also drives an active-high ready line that holds the processor while a slow peripheral is being accessed. Three configuration straps set the memory map and the timing: a ROM-size strap, one wait strap for each I/O page, and a bypass strap that turns off all stalling.

The top 768 bytes below the last page form an I/O hole. Page `$FC00` is split into eight 32-byte slots, and this page can be set to 0 or 2 wait states. Page `$FD00` is split the same way and can be set to 0 or 1 wait state. Page `$FE00` is left undecoded. ROM occupies the top 16 KB or 32 KB, minus the hole, and RAM fills the rest of the address space.

When a slow slot is selected, ready drops in the same cycle as the select. It stays low for the programmed number of cycles, then rises for exactly one cycle so the transfer can finish. The processor keeps its address on the bus during the stall, and this does not restart the count. The cycle after ready rises is a new access.

Top module: `bus_stall_decoder`

## Requirements
- R1: With `rom_32k_i`=1, `ram_cs_no` is low exactly for addresses `$0000`-`$7FFF`. With `rom_32k_i`=0, it is low exactly for `$0000`-`$BFFF`. In both cases `addr_vld_i` must be 1.
- R2: With `rom_32k_i`=1, `rom_cs_no` is low for `$8000`-`$FFFF`. With `rom_32k_i`=0, it is low for `$C000`-`$FFFF`. In both cases `addr_vld_i` must be 1, and addresses `$FC00`-`$FEFF` are excluded.
- R3: Address `$FCxx` drives `io_cs_no[addr[7:5]]` low. Address `$FDxx` drives `io_cs_no[8+addr[7:5]]` low. At most one select of all eighteen is low at any time.
- R4: Page `$FExx` and any cycle with `addr_vld_i`=0 assert no select.
- R5: With `fc_wait_i`=1, an access to `$FCxx` sees `rdy_o` low for 2 cycles and then high for 1 cycle. With `fc_wait_i`=0, `rdy_o` stays high.
- R6: With `fd_wait_i`=1, an access to `$FDxx` sees `rdy_o` low for 1 cycle and then high for 1 cycle. With `fd_wait_i`=0, `rdy_o` stays high.
- R7: `rdy_o` goes low combinationally, in the same cycle the slow select first goes low.
- R8: Holding the address during the stall does not extend it. After the single high cycle, a held address counts as a new access and stalls again.
- R9: If the select goes inactive during a stall, `rdy_o` goes high at once. A later access restarts the full count.
- R10: With `nowait_i`=1, `rdy_o` stays high while the selects still decode.
- R11: While `rst_ni` is low, `rdy_o` is high and all selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Address bus |
| addr_vld_i | input | 1 | Address is valid this cycle |
| rom_32k_i | input | 1 | 1: 32 KB ROM, 0: 16 KB ROM |
| fc_wait_i | input | 1 | Page `$FC` gets 2 wait states |
| fd_wait_i | input | 1 | Page `$FD` gets 1 wait state |
| nowait_i | input | 1 | Disable all wait states |
| ram_cs_no | output | 1 | RAM select, active low |
| rom_cs_no | output | 1 | ROM select, active low |
| io_cs_no | output | 16 | Slot selects, active low; bits 7:0 page `$FC`, bits 15:8 page `$FD` |
| rdy_o | output | 1 | Ready to processor, active high |

## Verification
The stall counter is the only internal state, and every fault in it shows on `rdy_o` within three cycles of a slow select. A count that is too long or too short moves the single high cycle. A lost completion state lets a held address stall forever, or drop back into a stall without the one-cycle release. A missing abort path keeps ready low after the processor has left the slot. The decode is stateless, so every decoding error is visible in the same cycle as the address.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } stall_st_e;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned PAGES    = 2;
  localparam int unsigned SLOTS    = 8;
  localparam int unsigned IO_W     = PAGES * SLOTS;
  localparam int unsigned WS_SLOW  = 2;
  localparam int unsigned WS_MED   = 1;
  localparam int unsigned CNT_W    = $clog2(WS_SLOW + 1);
endpackage

// File: rtl/bsd_rst_sync.sv
module bsd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bsd_decode.sv
module bsd_decode
  import bsd_pkg::*;
#(
  parameter logic [7:0] IO_PAGE   = 8'hFC,
  parameter logic [7:0] HOLE_LAST = 8'hFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vld_i,
  input  logic              rom_32k_i,
  output logic              ram_cs_no,
  output logic              rom_cs_no,
  output logic [IO_W-1:0]   io_cs_no
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned PG_LSB = ADDR_W - 8;

  logic [7:0]        page;
  logic [SLOT_W-1:0] slot;
  logic              live;
  logic              in_hole;
  logic              upper_q;
  logic              upper_h;

  assign page    = addr_i[ADDR_W-1:PG_LSB];
  assign slot    = addr_i[PG_LSB-1 -: SLOT_W];
  assign live    = en_i & vld_i;
  assign in_hole = (page >= IO_PAGE) && (page <= HOLE_LAST);
  assign upper_h = addr_i[ADDR_W-1];
  assign upper_q = &addr_i[ADDR_W-1:ADDR_W-2];

  always_comb begin
    if (rom_32k_i) begin
      ram_cs_no = ~(live & ~upper_h);
      rom_cs_no = ~(live & upper_h & ~in_hole);
    end else begin
      ram_cs_no = ~(live & ~upper_q);
      rom_cs_no = ~(live & upper_q & ~in_hole);
    end
  end

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam logic [7:0] PG = 8'(IO_PAGE + p);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign io_cs_no[p*SLOTS+s] = ~(live && page == PG && slot == SLOT_W'(s));
    end
  end

  p_single_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~io_cs_no, ~ram_cs_no, ~rom_cs_no}));

  p_gap_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page == HOLE_LAST || !vld_i) |-> (&io_cs_no && rom_cs_no));
endmodule

// File: rtl/bsd_stall.sv
module bsd_stall
  import bsd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             rdy_o
);
  stall_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rdy_o = 1'b1;
    if (bypass_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_i && need_i != '0) begin
            rdy_o = 1'b0;
            cnt_d = need_i - 1'b1;
            st_d  = (need_i == CNT_W'(1)) ? ST_DONE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!req_i) begin
            st_d = ST_IDLE;
          end else begin
            rdy_o = 1'b0;
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) st_d = ST_DONE;
          end
        end
        ST_DONE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign cnt_en = (st_d == ST_WAIT) || (st_d == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  logic [3:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_run_q <= '0;
    else if (rdy_o) low_run_q <= '0;
    else            low_run_q <= low_run_q + 1'b1;
  end

  p_low_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(low_run_q) <= WS_SLOW);

  p_release_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |-> rdy_o);

  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !req_i) |-> (rdy_o ##1 st_q == ST_IDLE));

  p_bypass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> rdy_o);
endmodule

// File: rtl/bus_stall_decoder.sv
module bus_stall_decoder
  import bsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic              rom_32k_i,
  input  logic              fc_wait_i,
  input  logic              fd_wait_i,
  input  logic              nowait_i,
  output logic              ram_cs_no,
  output logic              rom_cs_no,
  output logic [IO_W-1:0]   io_cs_no,
  output logic              rdy_o
);
  logic             rst_n_int;
  logic             slow_hi_n;
  logic             slow_md_n;
  logic             slow_n;
  logic [CNT_W-1:0] need;

  bsd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  bsd_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .en_i      (rst_n_int),
    .addr_i    (addr_i),
    .vld_i     (addr_vld_i),
    .rom_32k_i (rom_32k_i),
    .ram_cs_no (ram_cs_no),
    .rom_cs_no (rom_cs_no),
    .io_cs_no  (io_cs_no)
  );

  // Merge the active-low selects of the slow slots: any low one stalls.
  assign slow_hi_n = &io_cs_no[SLOTS-1:0]    | ~fc_wait_i;
  assign slow_md_n = &io_cs_no[IO_W-1:SLOTS] | ~fd_wait_i;
  assign slow_n    = slow_hi_n & slow_md_n;
  assign need      = !slow_hi_n ? CNT_W'(WS_SLOW) :
                     !slow_md_n ? CNT_W'(WS_MED)  : '0;

  bsd_stall u_stall (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .bypass_i (nowait_i),
    .req_i    (~slow_n),
    .need_i   (need),
    .rdy_o    (rdy_o)
  );

  p_first_low_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($fell(slow_n) && !nowait_i && $past(rdy_o)) |-> !rdy_o);
endmodule

// File: tb/bus_stall_decoder_tb.sv
module bus_stall_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        vld, rom32, wfc, wfd, nowait;
  logic        ram_n, rom_n, rdy;
  logic [15:0] io_n;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  bus_stall_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .addr_vld_i(vld),
    .rom_32k_i(rom32), .fc_wait_i(wfc), .fd_wait_i(wfd), .nowait_i(nowait),
    .ram_cs_no(ram_n), .rom_cs_no(rom_n), .io_cs_no(io_n), .rdy_o(rdy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at addr %h: actual %h expected %h", req, addr, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_sel(logic [15:0] a, logic rb, logic v);
    logic [15:0] io;
    logic hole, ram, rom;
    io   = 16'hFFFF;
    hole = (a[15:8] >= 8'hFC) && (a[15:8] <= 8'hFE);
    ram  = rb ? (a < 16'h8000) : (a < 16'hC000);
    rom  = !hole && !ram;
    if (a[15:8] == 8'hFC) io[a[7:5]] = 1'b0;
    if (a[15:8] == 8'hFD) io[8 + a[7:5]] = 1'b0;
    if (!v) return 18'h3FFFF;
    return {io, ~ram, ~rom};
  endfunction

  // Drive at negedge, sample 2 ns later; n low cycles then one high.
  task automatic access(logic [15:0] a, int n, string req);
    @(negedge clk); addr = a; vld = 1'b1; #2;
    check(req, {31'd0, rdy}, (n == 0) ? 1 : 0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk); #2;
      check(req, {31'd0, rdy}, (k == n) ? 1 : 0);
    end
    @(negedge clk); #2;
    check("R8", {31'd0, rdy}, (n == 0) ? 1 : 0);
    @(negedge clk); vld = 1'b0; #2;
    check(req, {31'd0, rdy}, 1);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        bad++; total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; addr = 16'hFC00; vld = 1'b1;
    rom32 = 1'b0; wfc = 1'b1; wfd = 1'b1; nowait = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", {13'd0, io_n, ram_n, rom_n, rdy}, {13'd0, 16'hFFFF, 1'b1, 1'b1, 1'b1});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4: full address sweep, both ROM sizes, no wait states
    wfc = 1'b0; wfd = 1'b0;
    for (int rb = 0; rb < 2; rb++) begin
      rom32 = rb[0];
      for (int a = 0; a < 65536; a++) begin
        addr = a[15:0]; #1;
        check("R1/R2/R3", {13'd0, io_n, ram_n, rom_n, rdy},
              {13'd0, exp_sel(addr, rom32, 1'b1), 1'b1});
      end
    end
    vld = 1'b0;
    for (int a = 0; a < 65536; a += 97) begin
      addr = a[15:0]; #1;
      check("R4", {14'd0, io_n, ram_n, rom_n}, {14'd0, 18'h3FFFF});
    end
    @(negedge clk);

    // R5 R6 R7 R8: every slot, each wait strap
    for (int w = 0; w < 2; w++) begin
      wfc = w[0]; wfd = w[0];
      for (int s = 0; s < 8; s++) begin
        access({8'hFC, 3'(s), 5'd3}, w * 2, "R5/R7");
        access({8'hFD, 3'(s), 5'd17}, w, "R6/R7");
      end
    end
    access(16'hFE40, 0, "R4");
    access(16'h1234, 0, "R1");

    // R9: abort mid-stall then restart full count
    wfc = 1'b1;
    @(negedge clk); addr = 16'hFC20; vld = 1'b1; #2;
    check("R9", {31'd0, rdy}, 0);
    @(negedge clk); addr = 16'h0100; #2;
    check("R9", {31'd0, rdy}, 1);
    @(negedge clk); addr = 16'hFC20; #2;
    check("R9", {31'd0, rdy}, 0);
    @(negedge clk); #2;
    check("R9", {31'd0, rdy}, 0);
    @(negedge clk); #2;
    check("R9", {31'd0, rdy}, 1);
    @(negedge clk); vld = 1'b0;

    // R10: bypass keeps ready high, selects still decode
    nowait = 1'b1;
    @(negedge clk); addr = 16'hFC60; vld = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #2;
      check("R10", {15'd0, io_n, rdy}, {15'd0, 16'hFFF7, 1'b1});
      @(negedge clk);
    end
    nowait = 1'b0; vld = 1'b0;
    @(negedge clk);

    // R11: asynchronous reset mid-stall
    @(negedge clk); addr = 16'hFC00; vld = 1'b1; #2;
    check("R7", {31'd0, rdy}, 0);
    rst_n = 1'b0; #1;
    check("R11", {15'd0, io_n, rdy}, {15'd0, 16'hFFFF, 1'b1});
    @(negedge clk); rst_n = 1'b1; vld = 1'b0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule